// File: doc/BRIEF.md
# Packed G-Float to Signed Quadword Converter

This block turns a 64-bit G-format floating-point register value into a signed 64-bit integer. The register layout is sign in bit 63, an 11-bit excess-1024 exponent in bits 62:52 and a 52-bit fraction in bits 51:0. The significand has a hidden leading one and reads as 0.1fff... times two to the power of (exponent field minus 1024). The caller chooses between truncation and round-half-away-from-zero with a per-operation mode bit. A second bit decides whether an integer overflow is reported.

Each operation starts with a one-cycle strobe. The result and its two flags appear on registered outputs one clock later. Reserved encodings give zero and raise an invalid flag. Results that do not fit in 64 bits are not saturated: they keep their low 64 bits. The overflow flag is only a report, and acting on it belongs to the surrounding pipeline.

Top module: `g2q_cvt`

## Requirements
- R1: While rst_ni is low, valid_o, res_o, inv_o and ovf_o are all zero.
- R2: Every cycle with valid_i high produces exactly one cycle with valid_o high, on the next clock edge, and results keep the order of their operations.
- R3: An operand of all zero bits gives res_o = 0 with inv_o and ovf_o low.
- R4: An operand whose exponent field (bits 62:52) is zero but which has some other bit set is reserved. It gives res_o = 0 and inv_o = 1 whatever trap_en_i is, and ovf_o = 0.
- R5: If the exponent field is between 1 and 1023 (a magnitude below one half), res_o is 0 in both rounding modes and ovf_o is 0.
- R6: With round_i = 0, fraction bits below the integer LSB are discarded (truncation toward zero). For example, 1.5 gives 1, 2.5 gives 2 and 0.5 gives 0.
- R7: With round_i = 1, one is added at the bit just below the integer LSB before that bit is discarded. For example, 0.5 gives 1, 1.5 gives 2, 2.5 gives 3 and -2.5 gives -3.
- R8: When bit 63 of the operand is set, res_o is the two's complement of the converted magnitude.
- R9: For exponent fields up to 1087, ovf_o is 1 only if trap_en_i is 1 and the magnitude exceeds 2^63-1 (positive) or 2^63 (negative). The largest such operand gives 0x7FFFFFFFFFFFFC00 with no flag.
- R10: For exponent fields of 1088 to 1151, the significand (leading one at bit 63) is shifted left by (field - 1088) and only the low 64 bits are kept. Above 1151 the magnitude is 0. In both cases ovf_o equals trap_en_i.
- R11: With trap_en_i = 0, ovf_o is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 64 | Packed G-format operand |
| round_i | input | 1 | 1 = round at half, 0 = truncate |
| trap_en_i | input | 1 | Enables the overflow flag |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| res_o | output | 64 | Signed 64-bit integer result |
| inv_o | output | 1 | Reserved-operand flag |
| ovf_o | output | 1 | Integer overflow flag |

## Verification
The bench converts exact halves such as 0.5, 1.5 and 2.5 of both signs in both rounding modes. A design that rounds to even or rounds toward zero would return 2 where 3 is expected, or 0 where 1 is expected. Reserved operands are sent with the trap enable off, which catches a design that gates the invalid flag or passes fraction bits through. Operands of exactly plus and minus 2^63, the largest in-range magnitude, and wrapping exponents of 1089, 1090 and above 1151 catch designs that saturate, get the shift off by one, or flag overflow on the in-range path or with the enable off.

// File: rtl/g2q_pkg.sv
package g2q_pkg;
  localparam int WORD_W  = 64;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = WORD_W - 1 - EXP_W;
  localparam int GUARD_W = WORD_W - 1 - FRAC_W;
  localparam int BIAS    = 1 << (EXP_W - 1);
  localparam int UEXP_W  = EXP_W + 2;
  localparam int SH_W    = $clog2(WORD_W);
endpackage

// File: rtl/g2q_unpack.sv
module g2q_unpack
  import g2q_pkg::*;
(
  input  logic [WORD_W-1:0]        op_i,
  output logic                     sign_o,
  output logic signed [UEXP_W-1:0] uexp_o,
  output logic [WORD_W-1:0]        mant_o,
  output logic                     exp_zero_o,
  output logic                     rsvd_o
);
  logic [EXP_W-1:0] exp_f;

  assign exp_f      = op_i[WORD_W-2 -: EXP_W];
  assign sign_o     = op_i[WORD_W-1];
  assign exp_zero_o = (exp_f == '0);
  assign rsvd_o     = exp_zero_o && (op_i != '0);
  assign uexp_o     = $signed({2'b00, exp_f}) - $signed(UEXP_W'(BIAS));
  // hidden one lands at the MSB, guard zeros below the fraction
  assign mant_o     = {1'b1, op_i[FRAC_W-1:0], {GUARD_W{1'b0}}};
endmodule

// File: rtl/g2q_align.sv
module g2q_align
  import g2q_pkg::*;
(
  input  logic [WORD_W-1:0]        mant_i,
  input  logic signed [UEXP_W-1:0] uexp_i,
  input  logic                     round_i,
  output logic [WORD_W-1:0]        mag_o,
  output logic                     big_o
);
  localparam int TOP      = WORD_W - 1;
  localparam int WRAP_MAX = 2 * WORD_W - 1;

  logic [WORD_W:0]   ext;
  logic [SH_W-1:0]   rsh;
  logic [SH_W-1:0]   lsh;

  always_comb begin
    mag_o = '0;
    big_o = 1'b0;
    ext   = '0;
    rsh   = '0;
    lsh   = '0;
    if (uexp_i < 0) begin
      mag_o = '0;
    end else if (uexp_i <= TOP) begin
      // keep one bit below the integer LSB for rounding
      rsh   = SH_W'(TOP - int'(uexp_i));
      ext   = {1'b0, mant_i} >> rsh;
      ext   = ext + (WORD_W+1)'(round_i);
      mag_o = ext[WORD_W:1];
    end else begin
      big_o = 1'b1;
      if (uexp_i <= WRAP_MAX) begin
        lsh   = SH_W'(int'(uexp_i) - WORD_W);
        mag_o = mant_i << lsh;
      end
    end
  end
endmodule

// File: rtl/g2q_finish.sv
module g2q_finish
  import g2q_pkg::*;
(
  input  logic [WORD_W-1:0] mag_i,
  input  logic              sign_i,
  input  logic              big_i,
  input  logic              kill_i,
  input  logic              trap_en_i,
  output logic [WORD_W-1:0] res_o,
  output logic              ovf_o
);
  logic [WORD_W-1:0] limit;

  assign limit = sign_i ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
  assign ovf_o = trap_en_i && !kill_i && (big_i || (mag_i > limit));
  assign res_o = kill_i ? '0 : (sign_i ? (~mag_i + 1'b1) : mag_i);
endmodule

// File: rtl/g2q_cvt.sv
module g2q_cvt
  import g2q_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] op_i,
  input  logic              round_i,
  input  logic              trap_en_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] res_o,
  output logic              inv_o,
  output logic              ovf_o
);
  logic                     sign;
  logic signed [UEXP_W-1:0] uexp;
  logic [WORD_W-1:0]        mant;
  logic                     exp_zero;
  logic                     rsvd;
  logic [WORD_W-1:0]        mag;
  logic                     big;
  logic [WORD_W-1:0]        res_d;
  logic                     ovf_d;

  g2q_unpack u_unpack (
    .op_i       (op_i),
    .sign_o     (sign),
    .uexp_o     (uexp),
    .mant_o     (mant),
    .exp_zero_o (exp_zero),
    .rsvd_o     (rsvd)
  );

  g2q_align u_align (
    .mant_i  (mant),
    .uexp_i  (uexp),
    .round_i (round_i),
    .mag_o   (mag),
    .big_o   (big)
  );

  g2q_finish u_finish (
    .mag_i     (mag),
    .sign_i    (sign),
    .big_i     (big),
    .kill_i    (exp_zero),
    .trap_en_i (trap_en_i),
    .res_o     (res_d),
    .ovf_o     (ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      inv_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= res_d;
        inv_o <= rsvd;
        ovf_o <= ovf_d;
      end
    end
  end
endmodule

// File: rtl/g2q_cvt_chk.sv
module g2q_cvt_chk
  import g2q_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [WORD_W-1:0] op_i,
  input logic              trap_en_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] res_o,
  input logic              inv_o,
  input logic              ovf_o
);
  logic [EXP_W-1:0] exp_f;
  assign exp_f = op_i[WORD_W-2 -: EXP_W];

  AST_RESULT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == '0) |=> (res_o == '0 && !inv_o && !ovf_o)); // R3
  AST_RSVD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && exp_f == '0 && op_i != '0) |=> (inv_o && res_o == '0 && !ovf_o)); // R4
  AST_SUB_HALF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && exp_f != '0 && exp_f < EXP_W'(BIAS)) |=> (res_o == '0 && !ovf_o)); // R5
  AST_NO_OVF_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !trap_en_i) |=> !ovf_o); // R11
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(inv_o && ovf_o)); // R4
endmodule

bind g2q_cvt g2q_cvt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .trap_en_i (trap_en_i),
  .valid_o   (valid_o),
  .res_o     (res_o),
  .inv_o     (inv_o),
  .ovf_o     (ovf_o)
);

// File: tb/g2q_cvt_tb.sv
module g2q_cvt_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] op_i = '0;
  logic        round_i = 1'b0;
  logic        trap_en_i = 1'b0;
  logic        valid_o;
  logic [63:0] res_o;
  logic        inv_o;
  logic        ovf_o;

  typedef struct {
    logic [63:0] res;
    logic        inv;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  always #2 clk_i = ~clk_i;

  g2q_cvt u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .round_i   (round_i),
    .trap_en_i (trap_en_i),
    .valid_o   (valid_o),
    .res_o     (res_o),
    .inv_o     (inv_o),
    .ovf_o     (ovf_o)
  );

  function automatic logic [63:0] mk(input logic s, input int ue, input logic [51:0] f);
    logic [10:0] e;
    e = 11'(ue + 1024);
    return {s, e, f};
  endfunction

  task automatic drive(input logic [63:0] op, input logic rnd, input logic trp,
                       input logic [63:0] r, input logic iv, input logic ov, input string tag);
    exp_t it;
    @(negedge clk_i);
    op_i = op; round_i = rnd; trap_en_i = trp; valid_i = 1'b1;
    it.res = r; it.inv = iv; it.ovf = ov; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      exp_t it;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected result: res=%h expected no result", res_o);
      end else begin
        it = exp_q.pop_front();
        if (res_o !== it.res || inv_o !== it.inv || ovf_o !== it.ovf) begin
          n_bad++;
          $display("FAIL %s: res=%h inv=%b ovf=%b expected res=%h inv=%b ovf=%b",
                   it.tag, res_o, inv_o, ovf_o, it.res, it.inv, it.ovf);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_cmp++;
    if (valid_o !== 1'b0 || res_o !== '0 || inv_o !== 1'b0 || ovf_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: valid=%b res=%h inv=%b ovf=%b expected all zero",
               valid_o, res_o, inv_o, ovf_o);
    end
    rst_ni = 1'b1;
    idle(2);

    drive(64'h0, 1, 1, 64'h0, 0, 0, "R3 zero operand");
    drive(64'h0000_0000_0000_0001, 0, 0, 64'h0, 1, 0, "R4 reserved trap off");
    drive(64'h800F_0000_0000_0000, 1, 1, 64'h0, 1, 0, "R4 reserved signed");
    drive(mk(0, 1, 52'h8_0000_0000_0000), 0, 0, 64'd1, 0, 0, "R6 1.5 trunc");
    drive(mk(0, 1, 52'h8_0000_0000_0000), 1, 0, 64'd2, 0, 0, "R7 1.5 round");
    drive(mk(0, 2, 52'h4_0000_0000_0000), 0, 1, 64'd2, 0, 0, "R6 2.5 trunc");
    drive(mk(0, 2, 52'h4_0000_0000_0000), 1, 1, 64'd3, 0, 0, "R7 2.5 round");
    idle(1);
    drive(mk(1, 2, 52'h4_0000_0000_0000), 1, 1, 64'hFFFF_FFFF_FFFF_FFFD, 0, 0, "R8 R7 -2.5 round");
    drive(mk(1, 1, 52'h8_0000_0000_0000), 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R8 R6 -1.5 trunc");
    drive(mk(0, 0, 52'h0), 1, 0, 64'd1, 0, 0, "R7 0.5 round");
    drive(mk(0, 0, 52'h0), 0, 0, 64'd0, 0, 0, "R6 0.5 trunc");
    drive(mk(0, -1, 52'h0), 1, 1, 64'd0, 0, 0, "R5 0.25 round");
    drive(mk(1, -1000, 52'hF_FFFF_FFFF_FFFF), 1, 1, 64'd0, 0, 0, "R5 tiny negative");
    drive(mk(0, 63, 52'hF_FFFF_FFFF_FFFF), 1, 1, 64'h7FFF_FFFF_FFFF_FC00, 0, 0, "R9 largest in range");
    drive(mk(0, 64, 52'h0), 0, 1, 64'h8000_0000_0000_0000, 0, 1, "R10 +2^63 trap on");
    drive(mk(1, 64, 52'h0), 0, 1, 64'h8000_0000_0000_0000, 0, 1, "R10 -2^63 trap on");
    drive(mk(0, 64, 52'h0), 1, 0, 64'h8000_0000_0000_0000, 0, 0, "R11 +2^63 trap off");
    drive(mk(0, 65, 52'h8_0000_0000_0000), 0, 1, 64'h8000_0000_0000_0000, 0, 1, "R10 wrap shift 1");
    drive(mk(0, 66, 52'h0_0000_0000_0001), 0, 0, 64'h0000_0000_0000_2000, 0, 0, "R10 R11 wrap shift 2");
    drive(mk(0, 128, 52'h0), 1, 1, 64'h0, 0, 1, "R10 beyond wrap");
    drive(mk(1, 128, 52'h0), 1, 0, 64'h0, 0, 0, "R10 R11 beyond wrap trap off");
    idle(4);

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing results: %0d outstanding expected 0", exp_q.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule